// File: doc/BRIEF.md
# Stereo Volume Transition Controller

The block scales a stereo stream of signed samples by an attenuation level and sequences every change of that level over time. A one-cycle frame strobe marks each new left/right sample pair. Each channel keeps a current level in 1/8 dB units. That level moves toward a target taken from an 8-bit attenuation code, or toward full mute, in one of four transition styles. The first style applies the change at once. The second jumps to the target on a zero crossing of that channel's signal. The third walks toward the target in 1/8 dB steps, one step per frame. The fourth takes the same steps but lets each one happen only on a zero crossing. When no crossing arrives, a per-channel timeout forces the pending change.

A shared-volume control drives both channels from the channel-A code. A per-channel invert control flips the polarity of the samples. The gain is a computed dB-to-linear coefficient that multiplies each sample. The result is rounded back to the sample width, and the output is registered once per frame.

Top module: `vol_transition`

## Requirements
- R1: During and right after reset, out_l, out_r and out_vld are 0 and both channel levels are 0 (0 dB).
- R2: out_vld is high in exactly the cycle after each frame_stb. out_l and out_r update only then, and they are computed from the samples present with the strobe and from the level in effect before that clock edge.
- R3: For a level L below 1023 the coefficient is c = f[L mod 48] >> (L / 48), where f[0] = 65535 and f[k] = (f[k-1]*64596 + 32768) >> 16. The output is floor((x*c + 32768) / 65536), where x is the sample after any inversion.
- R4: A channel's target is its code times 4. While that channel's mute input is high its target is 1023 instead, and level 1023 produces an output of exactly 0.
- R5: With mode 2'b00, the level equals the target on the clock edge after the target appears, whether or not a strobe is present.
- R6: With mode 2'b10, the level moves one step (1/8 dB) toward the target on each strobe and holds between strobes.
- R7: With mode 2'b01, a pending change jumps the level straight to the target on a strobe whose sample is a zero crossing. A zero crossing is a sample equal to zero, or a sample whose sign bit differs from that of the channel's previous strobed sample. The previous sample is 0 after reset.
- R8: In modes 2'b01 and 2'b11, a pending change that sees no zero crossing is applied on the 1024th strobe after the wait began. The wait counter restarts after each applied change.
- R9: With mode 2'b11, the level moves one step toward the target only on strobes that are zero crossings or on which the timeout expires.
- R10: Zero-crossing detection and the timeout are evaluated separately for the left channel (A) and the right channel (B).
- R11: With single_vol high, channel B's target uses vol_a and vol_b has no effect. With single_vol low, channel B uses vol_b.
- R12: With a channel's invert input high, the sample is negated before the gain. An input of -32768 becomes +32767.
- R13: If the target changes during a ramp, the level continues stepping from its current value toward the new target, with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per left/right frame |
| in_l | input | 16 | Channel A signed sample |
| in_r | input | 16 | Channel B signed sample |
| vol_a | input | 8 | Channel A attenuation code, 1/2 dB units |
| vol_b | input | 8 | Channel B attenuation code, 1/2 dB units |
| mute_a | input | 1 | Channel A mute request |
| mute_b | input | 1 | Channel B mute request |
| single_vol | input | 1 | Drive both channels from vol_a |
| mode | input | 2 | Transition style: 00 instant, 01 zero cross, 10 ramp, 11 ramp gated by zero cross |
| inv_a | input | 1 | Channel A polarity inversion |
| inv_b | input | 1 | Channel B polarity inversion |
| out_l | output | 16 | Channel A scaled sample |
| out_r | output | 16 | Channel B scaled sample |
| out_vld | output | 1 | Output update pulse |

## Verification
The assertions assume that frame_stb is a single-cycle pulse. They also assume that the mode, volume and mute inputs seen on a clock edge are the ones that govern the level update made on that edge. A level step is therefore judged against the mode of the preceding cycle. The stimulus changes controls and samples only on falling edges, raises the strobe on one cycle out of every four, and holds the controls steady across each strobe. The sample patterns alternate in sign, stay positive for a long run, or sweep the whole range including -32768.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    typedef enum logic [1:0] {
        XF_INSTANT = 2'b00,
        XF_ZCROSS  = 2'b01,
        XF_RAMP    = 2'b10,
        XF_RAMPZC  = 2'b11
    } xf_mode_e;

    localparam int COEF_W     = 16;
    localparam int HALV_STEPS = 48;
    localparam longint COEF_ONE   = 65535;
    localparam longint COEF_RATIO = 64596;

    function automatic logic [COEF_W-1:0] frac_coef(input int k);
        longint v;
        v = COEF_ONE;
        for (int i = 0; i < k; i++) begin
            v = (v * COEF_RATIO + longint'(2 ** (COEF_W - 1))) >>> COEF_W;
        end
        return COEF_W'(v);
    endfunction

endpackage

// File: rtl/vtc_gain.sv
module vtc_gain #(
    parameter int SW = 16,
    parameter int LW = 10
) (
    input  logic signed [SW-1:0] smp,
    input  logic                 inv,
    input  logic [LW-1:0]        level,
    output logic signed [SW-1:0] y
);
    import vtc_pkg::*;

    localparam int IDX_W = $clog2(HALV_STEPS);
    localparam int PW    = SW + COEF_W + 2;
    localparam logic [LW-1:0]        MUTE_LVL = {LW{1'b1}};
    localparam logic signed [SW-1:0] SMIN     = {1'b1, {(SW-1){1'b0}}};
    localparam logic signed [SW:0]   SMAX_X   = {2'b00, {(SW-1){1'b1}}};
    localparam logic signed [PW-1:0] RND      = PW'(2 ** (COEF_W - 1));

    logic [COEF_W-1:0] frac [HALV_STEPS];

    for (genvar k = 0; k < HALV_STEPS; k++) begin : g_frac
        assign frac[k] = frac_coef(k);
    end

    logic [LW-1:0]        idx_full;
    logic [LW-1:0]        shift;
    logic [COEF_W-1:0]    coef;
    logic signed [SW:0]   x;
    logic signed [COEF_W:0] coef_s;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        idx_full = level % LW'(HALV_STEPS);
        shift    = level / LW'(HALV_STEPS);
        coef     = frac[idx_full[IDX_W-1:0]] >> shift;
        if (!inv)
            x = {smp[SW-1], smp};
        else if (smp == SMIN)
            x = SMAX_X;
        else
            x = -{smp[SW-1], smp};
        coef_s = {1'b0, coef};
        prod   = PW'(x) * PW'(coef_s);
        rnd    = (prod + RND) >>> COEF_W;
        y      = (level == MUTE_LVL) ? '0 : $signed(rnd[SW-1:0]);
    end

endmodule

// File: rtl/vtc_chan.sv
module vtc_chan #(
    parameter int SW = 16,
    parameter int LW = 10,
    parameter int TW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic signed [SW-1:0] smp,
    input  logic [LW-1:0]        target,
    input  logic [1:0]           mode,
    output logic [LW-1:0]        level
);
    import vtc_pkg::*;

    localparam logic [TW-1:0] TMO_MAX = {TW{1'b1}};

    typedef struct packed {
        logic [LW-1:0] level;
        logic [SW-1:0] prev;
        logic [TW-1:0] tmo;
    } chan_st_t;

    chan_st_t st_d, st_q;
    xf_mode_e xf;
    logic     zc;
    logic     fire;
    logic [LW-1:0] step;

    always_comb begin
        st_d = st_q;
        xf   = xf_mode_e'(mode);
        zc   = (smp == '0) || (smp[SW-1] != st_q.prev[SW-1]);
        fire = !xf[0] || zc || (st_q.tmo == TMO_MAX);
        step = (target > st_q.level) ? st_q.level + 1'b1 : st_q.level - 1'b1;
        if (stb)
            st_d.prev = smp;
        if (st_q.level == target) begin
            st_d.tmo = '0;
        end else if (xf == XF_INSTANT) begin
            st_d.level = target;
            st_d.tmo   = '0;
        end else if (stb) begin
            if (fire) begin
                st_d.level = xf[1] ? step : target;
                st_d.tmo   = '0;
            end else begin
                st_d.tmo = st_q.tmo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign level = st_q.level;

    assert_ramp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1]) |=> (level == $past(level) || level == $past(level) + 1'b1
                       || level == $past(level) - 1'b1));

    assert_hold_between_frames_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !stb) |=> $stable(level));

    assert_timeout_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && mode[0] && st_q.tmo == TMO_MAX && level != target)
        |=> (level != $past(level)));

endmodule

// File: rtl/vol_transition.sv
module vol_transition #(
    parameter int SW = 16,
    parameter int VW = 8,
    parameter int TW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic signed [SW-1:0] in_l,
    input  logic signed [SW-1:0] in_r,
    input  logic [VW-1:0]        vol_a,
    input  logic [VW-1:0]        vol_b,
    input  logic                 mute_a,
    input  logic                 mute_b,
    input  logic                 single_vol,
    input  logic [1:0]           mode,
    input  logic                 inv_a,
    input  logic                 inv_b,
    output logic signed [SW-1:0] out_l,
    output logic signed [SW-1:0] out_r,
    output logic                 out_vld
);
    localparam int LW = VW + 2;
    localparam int NCH = 2;
    localparam logic [LW-1:0] MUTE_LVL = {LW{1'b1}};

    typedef struct packed {
        logic [SW-1:0] out_l;
        logic [SW-1:0] out_r;
        logic          vld;
    } top_st_t;

    top_st_t top_d, top_q;

    logic signed [SW-1:0] smp   [NCH];
    logic [VW-1:0]        code  [NCH];
    logic                 mute  [NCH];
    logic                 inv   [NCH];
    logic [LW-1:0]        tgt   [NCH];
    logic [LW-1:0]        lvl   [NCH];
    logic signed [SW-1:0] y     [NCH];

    assign smp[0]  = in_l;
    assign smp[1]  = in_r;
    assign code[0] = vol_a;
    assign code[1] = single_vol ? vol_a : vol_b;
    assign mute[0] = mute_a;
    assign mute[1] = mute_b;
    assign inv[0]  = inv_a;
    assign inv[1]  = inv_b;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign tgt[c] = mute[c] ? MUTE_LVL : {code[c], 2'b00};

        vtc_chan #(.SW(SW), .LW(LW), .TW(TW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (frame_stb),
            .smp    (smp[c]),
            .target (tgt[c]),
            .mode   (mode),
            .level  (lvl[c])
        );

        vtc_gain #(.SW(SW), .LW(LW)) u_gain (
            .smp   (smp[c]),
            .inv   (inv[c]),
            .level (lvl[c]),
            .y     (y[c])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.vld = frame_stb;
        if (frame_stb) begin
            top_d.out_l = y[0];
            top_d.out_r = y[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            top_q <= '0;
        else
            top_q <= top_d;
    end

    assign out_l   = $signed(top_q.out_l);
    assign out_r   = $signed(top_q.out_r);
    assign out_vld = top_q.vld;

    assert_mute_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && lvl[0] == MUTE_LVL) |=> (out_l == '0));

    assert_shared_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (single_vol && mode == 2'b00 && mute_a == mute_b) |=> (lvl[0] == lvl[1]));

    assert_out_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb) |=> ($stable(out_l) && $stable(out_r)));

endmodule

// File: tb/sim_vol_transition.sv
`timescale 1ns/1ps
module sim_vol_transition;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic signed [15:0] in_l = '0, in_r = '0;
    logic [7:0] vol_a = '0, vol_b = '0;
    logic mute_a = 1'b0, mute_b = 1'b0, single_vol = 1'b0;
    logic [1:0] mode = 2'b00;
    logic inv_a = 1'b0, inv_b = 1'b0;
    logic signed [15:0] out_l, out_r;
    logic out_vld;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    vol_transition u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(stb), .in_l(in_l), .in_r(in_r),
        .vol_a(vol_a), .vol_b(vol_b), .mute_a(mute_a), .mute_b(mute_b),
        .single_vol(single_vol), .mode(mode), .inv_a(inv_a), .inv_b(inv_b),
        .out_l(out_l), .out_r(out_r), .out_vld(out_vld)
    );

    // reference model state
    longint fr [48];
    int lvl [2];
    int prv [2];
    int tmo [2];
    int e_out [2];
    bit e_vld;

    initial begin
        fr[0] = 65535;
        for (int k = 1; k < 48; k++) fr[k] = (fr[k-1] * 64596 + 32768) >>> 16;
    end

    function automatic int gainf(int s, bit iv, int l);
        int x;
        longint p;
        if (iv) x = (s == -32768) ? 32767 : -s;
        else    x = s;
        if (l == 1023) return 0;
        p = longint'(x) * (fr[l % 48] >>> (l / 48));
        return int'((p + 32768) >>> 16);
    endfunction

    always @(posedge clk) begin
        int s [2];
        int tg [2];
        bit zc;
        bit fire;
        s[0] = int'(in_l);
        s[1] = int'(in_r);
        tg[0] = mute_a ? 1023 : int'(vol_a) * 4;
        tg[1] = mute_b ? 1023 : (single_vol ? int'(vol_a) : int'(vol_b)) * 4;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                lvl[c] = 0; prv[c] = 0; tmo[c] = 0; e_out[c] = 0;
            end
            e_vld = 0;
        end else begin
            e_vld = stb;
            for (int c = 0; c < 2; c++) begin
                if (stb) e_out[c] = gainf(s[c], c == 0 ? inv_a : inv_b, lvl[c]);
                zc = (s[c] == 0) || ((s[c] < 0) != (prv[c] < 0));
                if (stb) prv[c] = s[c];
                if (lvl[c] == tg[c]) tmo[c] = 0;
                else if (mode == 2'b00) begin lvl[c] = tg[c]; tmo[c] = 0; end
                else if (stb) begin
                    fire = (mode[0] == 1'b0) || zc || (tmo[c] == 1023);
                    if (fire) begin
                        if (mode[1]) lvl[c] = (tg[c] > lvl[c]) ? lvl[c] + 1 : lvl[c] - 1;
                        else         lvl[c] = tg[c];
                        tmo[c] = 0;
                    end else tmo[c] = tmo[c] + 1;
                end
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "out_l", int'(out_l), e_out[0]);
            check(cur_req, "out_r", int'(out_r), e_out[1]);
            check(cur_req, "out_vld", int'(out_vld), int'(e_vld));
        end
    end

    function automatic int pat(int p, int i);
        case (p)
            0: return (i % 2 == 0) ? 12000 + i % 500 : -11000 - i % 700;
            1: return 5000;
            2: return ((i * 7919) % 65536) - 32768;
            default: return (i % 2 == 0) ? -32768 : 32767;
        endcase
    endfunction

    task automatic frames(int n, int pl, int pr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            stb = 1'b1;
            in_l = 16'(pat(pl, i));
            in_r = 16'(pat(pr, i + 1));
            @(negedge clk);
            stb = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values seen at the ports
        check("R1", "out_l in reset", int'(out_l), 0);
        check("R1", "out_vld in reset", int'(out_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_r after reset", int'(out_r), 0);
        cur_req = "R2";
        frames(4, 2, 2);
        // R1: level 0 gives unity coefficient on the first frame
        check("R1", "unity gain", int'(out_l), gainf(pat(2, 3), 0, 0));

        cur_req = "R5"; mode = 2'b00; vol_a = 8'd10; vol_b = 8'd20;
        frames(6, 0, 2);
        cur_req = "R3"; vol_a = 8'd100; vol_b = 8'd3;
        frames(8, 2, 2);
        vol_a = 8'd255; vol_b = 8'd47;
        frames(6, 2, 0);

        cur_req = "R6"; mode = 2'b10; vol_a = 8'd30; vol_b = 8'd5;
        frames(140, 2, 2);
        cur_req = "R13"; vol_a = 8'd60;
        frames(20, 2, 0);
        vol_a = 8'd50;
        frames(80, 0, 2);

        cur_req = "R7"; mode = 2'b01; vol_a = 8'd20; vol_b = 8'd10;
        frames(4, 0, 0);
        cur_req = "R8"; vol_a = 8'd80; vol_b = 8'd70;
        frames(1030, 1, 1);
        cur_req = "R10"; vol_a = 8'd10; vol_b = 8'd20;
        frames(1030, 1, 0);

        cur_req = "R9"; mode = 2'b11; vol_a = 8'd16; vol_b = 8'd16;
        frames(30, 0, 0);
        vol_a = 8'd14; vol_b = 8'd18;
        frames(2060, 1, 1);

        cur_req = "R11"; mode = 2'b00; single_vol = 1'b1; vol_a = 8'd8; vol_b = 8'd200;
        frames(5, 2, 2);
        single_vol = 1'b0;
        frames(5, 2, 2);

        cur_req = "R12"; inv_a = 1'b1; inv_b = 1'b1; vol_a = 8'd0; vol_b = 8'd1;
        frames(6, 3, 3);
        inv_b = 1'b0;
        frames(4, 2, 3);
        inv_a = 1'b0;

        cur_req = "R4"; mute_a = 1'b1; mute_b = 1'b1;
        frames(3, 2, 2);
        check("R4", "muted out_l", int'(out_l), 0);
        check("R4", "muted out_r", int'(out_r), 0);
        mode = 2'b10; mute_a = 1'b0; vol_a = 8'd250;
        frames(40, 2, 2);
        mute_b = 1'b1; vol_b = 8'd4;
        frames(10, 2, 2);

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule